// File: doc/BRIEF.md
# Two-Stage Calendar Prescaler

This block turns the slow real-time-clock input (anywhere from roughly 32 kHz to about 1 MHz) into the once-per-second calendar tick. Two down-counters are chained. The first is a short asynchronous-style stage that emits an intermediate clock enable every A+1 input cycles. The second, wider stage advances only on those enables and emits the tick every S+1 of them. The tick rate is therefore the input rate divided by (A+1)*(S+1).

Both reload values live in one 32-bit configuration word. Software can change that word only while the calendar's initialization acknowledge is asserted. While initialization is active, both counters are held at their reload values, so leaving initialization restarts the divide chain from a clean phase. Software normally writes the word twice: first with only the synchronous value, then with both values. Every accepted write replaces the whole word.

Top module: `cal_prescaler`

## Requirements
- R1: After reset, the configuration reads 0x007F00FF (asynchronous reload 127, synchronous reload 255), and the enable and tick outputs are low.
- R2: The synchronous reload occupies configuration bits 14:0 and the asynchronous reload occupies bits 22:16. All other read bits are zero.
- R3: A configuration write while the initialization acknowledge is low is ignored. The read value and the tick period both stay unchanged.
- R4: Each accepted write replaces both fields from the written word. A write carrying only the synchronous field clears the asynchronous field.
- R5: While the initialization acknowledge is high, neither the intermediate enable nor the tick pulses.
- R6: Counting restarts when initialization is left. In the first cycle with the acknowledge low, both counters hold their reload values, so the first tick comes in cycle (A+1)*(S+1)-1, counting that first cycle as cycle 0. The same holds from reset release.
- R7: The intermediate enable is a one-cycle pulse that repeats every A+1 input cycles. It is high every cycle when A is 0.
- R8: The tick is a one-cycle pulse that repeats every (A+1)*(S+1) input cycles, and it only ever coincides with an intermediate enable.
- R9: Each tick period contains exactly S+1 intermediate enables, and the tick's own cycle is one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_active | input | 1 | Calendar initialization acknowledge; gates writes and holds the counters |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| ck_apre | output | 1 | Intermediate enable from the first stage |
| tick_1hz | output | 1 | Calendar tick pulse |

## Verification
The bench targets the degenerate settings where one or both reloads are zero. A design with an off-by-one terminal count would stretch those periods or drop the every-cycle enable. It times the first tick after leaving initialization, which exposes a design that keeps its old phase or loads stale reload values. It checks that a sync-only write wipes the asynchronous field, which catches a field-merging register. It also checks that a write outside initialization leaves both the read value and the period intact, which catches a missing write gate.

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int AW    = 7,
  parameter int SW    = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_active,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        ck_apre,
  output logic        tick_1hz
);

  localparam int A_LSB = 16;
  localparam logic [AW-1:0] A_INIT = AW'(A_RST);
  localparam logic [SW-1:0] S_INIT = SW'(S_RST);

  logic [AW-1:0] a_rld, a_cnt;
  logic [SW-1:0] s_rld, s_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rld <= A_INIT;
      s_rld <= S_INIT;
    end else if (cfg_we && init_active) begin
      a_rld <= cfg_wdata[A_LSB +: AW];
      s_rld <= cfg_wdata[SW-1:0];
    end
  end

  assign ck_apre  = !init_active && (a_cnt == '0);
  assign tick_1hz = ck_apre && (s_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= A_INIT;
      s_cnt <= S_INIT;
    end else if (init_active) begin
      a_cnt <= a_rld;
      s_cnt <= s_rld;
    end else if (ck_apre) begin
      a_cnt <= a_rld;
      s_cnt <= (s_cnt == '0) ? s_rld : s_cnt - 1'b1;
    end else begin
      a_cnt <= a_cnt - 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[SW-1:0] = s_rld;
    cfg_rdata[A_LSB +: AW] = a_rld;
  end

endmodule

// File: rtl/cal_prescaler_chk.sv
module cal_prescaler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init_active,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        ck_apre,
  input logic        tick_1hz
);

  // R5
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |-> (!ck_apre && !tick_1hz));

  // R8
  tick_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> ck_apre);

  // R3
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && init_active) |=> $stable(cfg_rdata));

  // R4
  full_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && init_active) |=>
      (cfg_rdata == {9'b0, $past(cfg_wdata[22:16]), 1'b0, $past(cfg_wdata[14:0])}));

  // R7
  enable_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_apre && cfg_rdata[22:16] != 7'd0) |=> !ck_apre);

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && cfg_rdata[22:16] != 7'd0) |=> !tick_1hz);

endmodule

bind cal_prescaler cal_prescaler_chk i_cal_prescaler_chk (
  .clk(clk), .rst_n(rst_n), .init_active(init_active), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ck_apre(ck_apre),
  .tick_1hz(tick_1hz)
);

// File: tb/test_cal_prescaler.sv
module test_cal_prescaler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_active = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic ck_apre, tick_1hz;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cal_prescaler i_cal_prescaler (
    .clk(clk), .rst_n(rst_n), .init_active(init_active), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ck_apre(ck_apre),
    .tick_1hz(tick_1hz)
  );

  localparam logic [31:0] VEC [7] = '{
    32'h0000_0000, 32'h0000_0003, 32'h0002_0000, 32'h0003_0004,
    32'h0006_0002, 32'h0000_0005, 32'h0001_0009
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic meas(output int n, output int apre);
    n = 0; apre = 0;
    forever begin
      @(negedge clk);
      if (ck_apre) apre++;
      if (tick_1hz || n > 40000) break;
      n++;
    end
  endtask

  initial begin
    #(190000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, ap, a, s, quiet;
    #12;
    // R1
    chk(cfg_rdata == 32'h007F_00FF, "R1 reset cfg", cfg_rdata, 32'h007F_00FF);
    chk(!ck_apre && !tick_1hz, "R1 reset outputs", {ck_apre, tick_1hz}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    meas(n, ap);
    // R6 default from reset
    chk(n == 32767, "R6 first tick after reset", n, 32767);
    chk(ap == 256, "R9 enables default", ap, 256);

    foreach (VEC[i]) begin
      a = int'(VEC[i][22:16]);
      s = int'(VEC[i][14:0]);
      @(posedge clk); #1 init_active = 1'b1;
      wr({17'd0, VEC[i][14:0]});
      // R4 sync-only write clears async field
      chk(cfg_rdata == {17'd0, VEC[i][14:0]}, "R4 sync-only write", cfg_rdata, s);
      wr(VEC[i] | 32'hFF80_8000);
      // R2 field positions, other bits zero
      chk(cfg_rdata == VEC[i], "R2 field layout", cfg_rdata, VEC[i]);
      quiet = 0;
      repeat (4) begin
        @(negedge clk);
        if (ck_apre || tick_1hz) quiet++;
      end
      // R5
      chk(quiet == 0, "R5 quiet in init", quiet, 0);
      @(posedge clk); #1 init_active = 1'b0;
      meas(n, ap);
      // R6
      chk(n == (a + 1) * (s + 1) - 1, "R6 restart phase", n, (a + 1) * (s + 1) - 1);
      meas(n, ap);
      // R8 period, R7/R9 enables per period
      chk(n == (a + 1) * (s + 1) - 1, "R8 tick period", n, (a + 1) * (s + 1) - 1);
      chk(ap == s + 1, "R9 enables per tick", ap, s + 1);
      if (a == 0) begin
        @(negedge clk);
        // R7 every cycle when A is 0
        chk(ck_apre, "R7 enable every cycle", ck_apre, 1);
      end
    end

    // R3: write with init low ignored; last config A=1,S=9 (period 20)
    wr(32'h0000_0000);
    chk(cfg_rdata == 32'h0001_0009, "R3 ignored write cfg", cfg_rdata, 32'h0001_0009);
    meas(n, ap);
    meas(n, ap);
    chk(n == 19, "R3 period unchanged", n, 19);
    chk(ap == 10, "R3 enables unchanged", ap, 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule